// File: doc/BRIEF.md
# Vector Gather Address Generator

This block turns one vector gather operation into a series of single-element memory reads and assembles the destination vector from the data that comes back. A start pulse captures the operands: a 64-bit base, a signed displacement, a 2-bit scale code, a vector of indices, a per-element mask, the previous destination value, and three mode inputs. The modes are index width, data width and address size. The index width and the data width are chosen independently of each other and of the base.

For every active element the block forms an effective address and issues one request on a simple valid/ready read port. Responses come back in request order, and each one is written into its destination lane. When the last active element has returned, the block drops busy and pulses done. If 64-bit indices are paired with 32-bit data, only half the lanes can be addressed, and the upper half of the destination is cleared.

Top module: `vg_agen`

## Requirements
- R1: Each request address equals base + sign-extended displacement + (extended index shifted left by the scale code), where scale codes 0, 1, 2 and 3 give multipliers of 1, 2, 4 and 8.
- R2: When `idx_wide_i`=0, element k takes the 32-bit index at `idx_vec_i[32k+31:32k]` and sign-extends it to 64 bits. When `idx_wide_i`=1, it takes the 64-bit index at `idx_vec_i[64k+63:64k]`. The base is always 64 bits, whatever the index width.
- R3: The address is truncated to the address-size mode. `addr_mode_i`=0 keeps bits 15:0, 1 keeps bits 31:0, and 2 or 3 keep all 64 bits. The bits above the kept width read as zero.
- R4: The element count is 8 when `idx_wide_i`=0 and `data_wide_i`=0, and 4 in every other combination. Mask bits at or above the element count are ignored.
- R5: When `idx_wide_i`=1 and `data_wide_i`=0, bits 255:128 of the destination become zero, whatever `old_dst_i` holds.
- R6: An element whose mask bit `mask_i[k]` is clear issues no request, and its lane keeps the value from `old_dst_i`.
- R7: Requests go out in ascending element order, at most one per cycle. A request that is not accepted holds its address until `req_ready_i` is high. `req_wide_o` equals the captured data width.
- R8: Responses fill the lanes in request order. With 32-bit data, `rsp_data_i[31:0]` goes to `dst_o[32k+31:32k]`. With 64-bit data, all of `rsp_data_i` goes to `dst_o[64k+63:64k]`.
- R9: `busy_o` rises in the cycle after an accepted start that has at least one active element, and falls at the edge that takes the last response. `done_o` is a one-cycle pulse at that same edge. An operation with no active element pulses `done_o` one cycle after start, never raises busy and issues no request.
- R10: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures all operands |
| base_i | input | 64 | Base address |
| disp_i | input | DISP_W | Signed displacement |
| scale_i | input | 2 | Scale code (shift amount 0..3) |
| idx_vec_i | input | VEC_W | Index vector |
| idx_wide_i | input | 1 | 1 = 64-bit indices, 0 = 32-bit indices |
| data_wide_i | input | 1 | 1 = 64-bit data elements, 0 = 32-bit |
| addr_mode_i | input | 2 | Address size: 0 = 16, 1 = 32, 2/3 = 64 bits |
| mask_i | input | NSLOT | Per-element enable, bit k for element k |
| old_dst_i | input | VEC_W | Previous destination value |
| req_valid_o | output | 1 | Read request valid |
| req_addr_o | output | 64 | Read request address |
| req_wide_o | output | 1 | Request size: 1 = 64-bit, 0 = 32-bit |
| req_ready_i | input | 1 | Memory accepts the request |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | VEC_W | Assembled destination vector |

## Verification
The bench builds the block with its defaults: a 256-bit vector and a 32-bit displacement. With these values all four index/data width pairings can be exercised, giving 8 narrow lanes or 4 wide lanes, and the half-vector clearing of the upper 128 bits can be observed directly. The 32-bit displacement lets negative offsets, together with negative 32-bit indices, wrap a 64-bit base. That makes the sign extension and all three address-size truncations visible at the request port. A stalling ready pattern and a start pulse issued during an operation are applied with the same parameters.

// File: rtl/vg_pkg.sv
package vg_pkg;
   localparam int ADDR_W   = 64;
   localparam int NARROW_W = 32;
   localparam int WIDE_W   = 64;

   typedef enum logic [1:0] {
      AM_16  = 2'd0,
      AM_32  = 2'd1,
      AM_64  = 2'd2,
      AM_64X = 2'd3
   } amode_e;

   function automatic logic [ADDR_W-1:0] clip_addr(input logic [ADDR_W-1:0] a, input amode_e m);
      logic [ADDR_W-1:0] r;
      case (m)
         AM_16:   r = {48'd0, a[15:0]};
         AM_32:   r = {32'd0, a[31:0]};
         default: r = a;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/vg_elem_seq.sv
module vg_elem_seq #(
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [N-1:0]  mask_i,
   input  logic          step_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o,
   output logic          last_o
);
   logic [N-1:0] pend_q;
   logic [N-1:0] low_bit;

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_q[i]) idx_o = IW'(i);
      end
      low_bit = pend_q & (~pend_q + N'(1));
      any_o   = |pend_q;
      last_o  = any_o && (pend_q == low_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else if (load_i)
         pend_q <= mask_i;
      else if (step_i)
         pend_q <= pend_q & ~low_bit;
   end
endmodule

// File: rtl/vg_addr_calc.sv
module vg_addr_calc
   import vg_pkg::*;
#(
   parameter int VEC_W  = 256,
   parameter int DISP_W = 32,
   localparam int NN    = VEC_W / NARROW_W,
   localparam int NWD   = VEC_W / WIDE_W,
   localparam int IW    = $clog2(NN)
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [1:0]        scale_i,
   input  logic [VEC_W-1:0]  idx_vec_i,
   input  logic              idx_wide_i,
   input  amode_e            mode_i,
   input  logic [IW-1:0]     elem_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] nidx [NN];
   logic [ADDR_W-1:0] widx [NWD];
   logic [ADDR_W-1:0] sel_idx;
   logic [ADDR_W-1:0] disp_x;
   logic [ADDR_W-1:0] raw;

   for (genvar g = 0; g < NN; g++) begin : g_narrow
      assign nidx[g] = {{(ADDR_W-NARROW_W){idx_vec_i[g*NARROW_W+NARROW_W-1]}},
                        idx_vec_i[g*NARROW_W +: NARROW_W]};
   end
   for (genvar g = 0; g < NWD; g++) begin : g_wide
      assign widx[g] = idx_vec_i[g*WIDE_W +: WIDE_W];
   end

   if (DISP_W < ADDR_W) begin : g_dext
      assign disp_x = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
   end else begin : g_dfull
      assign disp_x = disp_i[ADDR_W-1:0];
   end

   always_comb begin
      sel_idx = '0;
      for (int k = 0; k < NN; k++) begin
         if (!idx_wide_i && elem_i == IW'(k)) sel_idx = nidx[k];
      end
      for (int k = 0; k < NWD; k++) begin
         if (idx_wide_i && elem_i == IW'(k)) sel_idx = widx[k];
      end
      raw    = base_i + disp_x + (sel_idx << scale_i);
      addr_o = clip_addr(raw, mode_i);
   end
endmodule

// File: rtl/vg_assemble.sv
module vg_assemble
   import vg_pkg::*;
#(
   parameter int VEC_W = 256,
   localparam int NN   = VEC_W / NARROW_W,
   localparam int NWD  = VEC_W / WIDE_W,
   localparam int IW   = $clog2(NN),
   localparam int HALF = VEC_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [VEC_W-1:0]  old_dst_i,
   input  logic              half_clr_i,
   input  logic              wr_en_i,
   input  logic              wr_wide_i,
   input  logic [IW-1:0]     wr_idx_i,
   input  logic [WIDE_W-1:0] wr_data_i,
   output logic [VEC_W-1:0]  dst_o
);
   logic [VEC_W-1:0] dst_q;
   logic [VEC_W-1:0] dst_d;

   always_comb begin
      dst_d = dst_q;
      if (load_i) begin
         dst_d = old_dst_i;
         if (half_clr_i) dst_d[VEC_W-1:HALF] = '0;
      end else if (wr_en_i) begin
         for (int k = 0; k < NN; k++) begin
            if (!wr_wide_i && wr_idx_i == IW'(k))
               dst_d[k*NARROW_W +: NARROW_W] = wr_data_i[NARROW_W-1:0];
         end
         for (int k = 0; k < NWD; k++) begin
            if (wr_wide_i && wr_idx_i == IW'(k))
               dst_d[k*WIDE_W +: WIDE_W] = wr_data_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dst_q <= '0;
      else        dst_q <= dst_d;
   end

   assign dst_o = dst_q;
endmodule

// File: rtl/vg_agen.sv
module vg_agen
   import vg_pkg::*;
#(
   parameter int VEC_W  = 256,
   parameter int DISP_W = 32,
   parameter int NSLOT  = VEC_W / 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [63:0]       base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [1:0]        scale_i,
   input  logic [VEC_W-1:0]  idx_vec_i,
   input  logic              idx_wide_i,
   input  logic              data_wide_i,
   input  logic [1:0]        addr_mode_i,
   input  logic [NSLOT-1:0]  mask_i,
   input  logic [VEC_W-1:0]  old_dst_i,
   output logic              req_valid_o,
   output logic [63:0]       req_addr_o,
   output logic              req_wide_o,
   input  logic              req_ready_i,
   input  logic              rsp_valid_i,
   input  logic [63:0]       rsp_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [VEC_W-1:0]  dst_o
);
   localparam int NN = VEC_W / NARROW_W;
   localparam int IW = $clog2(NN);

   if (VEC_W % WIDE_W != 0 || VEC_W < 2 * WIDE_W) begin : g_bad_vec
      $error("VEC_W must be a multiple of 64 and at least 128");
   end
   if (NSLOT != NN) begin : g_bad_slot
      $error("NSLOT must equal VEC_W/32");
   end
   if (DISP_W < 8 || DISP_W > ADDR_W) begin : g_bad_disp
      $error("DISP_W out of range");
   end

   logic [63:0]       base_q;
   logic [DISP_W-1:0] disp_q;
   logic [1:0]        scale_q;
   logic [VEC_W-1:0]  idx_q;
   logic              idx_wide_q;
   logic              data_wide_q;
   amode_e            mode_q;
   logic              busy_q;
   logic              done_q;

   logic              start_acc;
   logic [NN-1:0]     lim_mask;
   logic [NN-1:0]     act_mask;
   logic              iss_any, iss_last, rsp_any, rsp_last;
   logic [IW-1:0]     iss_idx, rsp_idx;
   logic              iss_step, rsp_step;

   assign start_acc = start_i && !busy_q;
   assign lim_mask  = (idx_wide_i || data_wide_i) ? {{(NN/2){1'b0}}, {(NN/2){1'b1}}}
                                                  : {NN{1'b1}};
   assign act_mask  = mask_i & lim_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q      <= '0;
         disp_q      <= '0;
         scale_q     <= '0;
         idx_q       <= '0;
         idx_wide_q  <= 1'b0;
         data_wide_q <= 1'b0;
         mode_q      <= AM_64;
      end else if (start_acc) begin
         base_q      <= base_i;
         disp_q      <= disp_i;
         scale_q     <= scale_i;
         idx_q       <= idx_vec_i;
         idx_wide_q  <= idx_wide_i;
         data_wide_q <= data_wide_i;
         mode_q      <= amode_e'(addr_mode_i);
      end
   end

   assign iss_step = req_valid_o && req_ready_i;
   assign rsp_step = rsp_valid_i && busy_q && rsp_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= (start_acc && !(|act_mask)) || (rsp_step && rsp_last);
         if (start_acc)
            busy_q <= |act_mask;
         else if (rsp_step && rsp_last)
            busy_q <= 1'b0;
      end
   end

   vg_elem_seq #(.N(NN)) u_iss (
      .clk(clk), .rst_n(rst_n), .load_i(start_acc), .mask_i(act_mask),
      .step_i(iss_step), .any_o(iss_any), .idx_o(iss_idx), .last_o(iss_last)
   );

   vg_elem_seq #(.N(NN)) u_rsp (
      .clk(clk), .rst_n(rst_n), .load_i(start_acc), .mask_i(act_mask),
      .step_i(rsp_step), .any_o(rsp_any), .idx_o(rsp_idx), .last_o(rsp_last)
   );

   vg_addr_calc #(.VEC_W(VEC_W), .DISP_W(DISP_W)) u_addr (
      .base_i(base_q), .disp_i(disp_q), .scale_i(scale_q), .idx_vec_i(idx_q),
      .idx_wide_i(idx_wide_q), .mode_i(mode_q), .elem_i(iss_idx), .addr_o(req_addr_o)
   );

   vg_assemble #(.VEC_W(VEC_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .load_i(start_acc), .old_dst_i(old_dst_i),
      .half_clr_i(idx_wide_i && !data_wide_i), .wr_en_i(rsp_step),
      .wr_wide_i(data_wide_q), .wr_idx_i(rsp_idx), .wr_data_i(rsp_data_i), .dst_o(dst_o)
   );

   assign req_valid_o = busy_q && iss_any;
   assign req_wide_o  = data_wide_q;
   assign busy_o      = busy_q;
   assign done_o      = done_q;
endmodule

// File: rtl/vg_agen_chk.sv
module vg_agen_chk #(
   parameter int VEC_W = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [1:0]       addr_mode_i,
   input logic             req_valid_o,
   input logic [63:0]      req_addr_o,
   input logic             req_ready_i,
   input logic             rsp_valid_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [VEC_W-1:0] dst_o
);
   logic [1:0] mode_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mode_seen <= 2'd2;
      else if (start_i && !busy_o) mode_seen <= addr_mode_i;
   end

   assert_req_in_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> busy_o);

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

   assert_addr_clip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && mode_seen == 2'd0) |-> (req_addr_o[63:16] == '0));

   assert_addr_clip32_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && mode_seen == 2'd1) |-> (req_addr_o[63:32] == '0));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_dst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_valid_i && !(start_i && !busy_o)) |=> $stable(dst_o));
endmodule

bind vg_agen vg_agen_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_mode_i(addr_mode_i),
   .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_ready_i(req_ready_i),
   .rsp_valid_i(rsp_valid_i), .busy_o(busy_o), .done_o(done_o), .dst_o(dst_o)
);

// File: tb/tb_vg_agen.sv
module tb_vg_agen;
   localparam int CLK_PERIOD = 10;
   localparam int VEC_W = 256;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [63:0]      base_i = '0;
   logic [31:0]      disp_i = '0;
   logic [1:0]       scale_i = '0;
   logic [VEC_W-1:0] idx_vec_i = '0;
   logic             idx_wide_i = 1'b0;
   logic             data_wide_i = 1'b0;
   logic [1:0]       addr_mode_i = 2'd2;
   logic [7:0]       mask_i = '0;
   logic [VEC_W-1:0] old_dst_i = '0;
   logic             req_valid_o, req_wide_o, busy_o, done_o;
   logic [63:0]      req_addr_o;
   logic             req_ready_i = 1'b1;
   logic             rsp_valid_i = 1'b0;
   logic [63:0]      rsp_data_i = '0;
   logic [VEC_W-1:0] dst_o;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int cyc = 0;
   logic [7:0] ready_pat = 8'hFF;

   logic [63:0]      exp_addr_q [$];
   string            exp_tag_q  [$];
   logic [VEC_W-1:0] exp_dst_q  [$];
   string            dst_tag_q  [$];

   vg_agen dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] mem_fn(input logic [63:0] a);
      return {a[31:0] ^ 32'h5A5A_1234, a[63:32] + a[31:0] + 32'h0101_0101};
   endfunction

   function automatic logic [63:0] ea(input logic [63:0] b, input logic [31:0] d,
                                      input logic [1:0] sc, input logic [VEC_W-1:0] iv,
                                      input logic iw, input int k, input logic [1:0] md);
      logic [63:0] x, s;
      if (iw) x = iv[64*k +: 64];
      else    x = {{32{iv[32*k+31]}}, iv[32*k +: 32]};
      s = b + {{32{d[31]}}, d} + (x << sc);
      if (md == 2'd0) s = s & 64'h0000_0000_0000_FFFF;
      else if (md == 2'd1) s = s & 64'h0000_0000_FFFF_FFFF;
      return s;
   endfunction

   task automatic check(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory model and monitor; all bench-side updates happen at the falling edge
   logic        hs_prev = 1'b0;
   logic [63:0] addr_prev = '0;
   always @(negedge clk) begin
      cyc++;
      rsp_valid_i = hs_prev;
      rsp_data_i  = hs_prev ? mem_fn(addr_prev) : 64'hDEAD_BEEF_DEAD_BEEF;
      req_ready_i = ready_pat[cyc % 8];
      hs_prev     = req_valid_o && req_ready_i;
      addr_prev   = req_addr_o;
      if (hs_prev) begin
         if (exp_addr_q.size() == 0) begin
            check("R7 unexpected request", {192'd0, req_addr_o}, '0);
         end else begin
            string t = exp_tag_q.pop_front();
            check(t, {192'd0, req_addr_o}, {192'd0, exp_addr_q.pop_front()});
         end
      end
      if (done_o) begin
         done_cnt++;
         if (exp_dst_q.size() == 0) begin
            check("R9 unexpected done", dst_o, '0);
         end else begin
            string t = dst_tag_q.pop_front();
            check(t, dst_o, exp_dst_q.pop_front());
         end
      end
   end

   // driver: predicts, pushes to the scoreboard, starts, waits for done
   task automatic run_op(input string tag, input logic [63:0] b, input logic [31:0] d,
                         input logic [1:0] sc, input logic [VEC_W-1:0] iv, input logic iw,
                         input logic dw, input logic [1:0] md, input logic [7:0] m,
                         input logic [VEC_W-1:0] od, input bit poke_busy);
      int n;
      logic [VEC_W-1:0] e;
      logic [7:0] act;
      int target;
      n = (iw || dw) ? 4 : 8;
      act = m & ((n == 4) ? 8'h0F : 8'hFF);
      e = od;
      if (iw && !dw) e[255:128] = '0;
      for (int k = 0; k < n; k++) begin
         if (act[k]) begin
            logic [63:0] a = ea(b, d, sc, iv, iw, k, md);
            exp_addr_q.push_back(a);
            exp_tag_q.push_back({tag, " addr"});
            if (dw) e[64*k +: 64] = mem_fn(a);
            else    e[32*k +: 32] = mem_fn(a)[31:0];
         end
      end
      exp_dst_q.push_back(e);
      dst_tag_q.push_back({tag, " dst"});
      target = done_cnt + 1;
      base_i = b; disp_i = d; scale_i = sc; idx_vec_i = iv; idx_wide_i = iw;
      data_wide_i = dw; addr_mode_i = md; mask_i = m; old_dst_i = od; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (act != 0) check({tag, " R9 busy after start"}, {255'd0, busy_o}, {255'd0, 1'b1});
      else          check({tag, " R9 empty done"}, {254'd0, busy_o, done_o}, {254'd0, 2'b01});
      if (poke_busy && act != 0) begin
         // R10: a second start mid-operation must not disturb anything
         base_i = 64'h1111_0000; mask_i = 8'hFF; idx_wide_i = 1'b0; data_wide_i = 1'b0;
         old_dst_i = {VEC_W{1'b1}}; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (done_cnt < target) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [VEC_W-1:0] pat(input logic [31:0] seed);
      logic [VEC_W-1:0] v;
      for (int i = 0; i < 8; i++) v[32*i +: 32] = seed * (i + 3) ^ {i[7:0], 24'h00A5C3};
      return v;
   endfunction

   initial begin
      logic [VEC_W-1:0] iv;
      repeat (3) @(negedge clk);
      check("R9 reset busy/done/req", {253'd0, busy_o, done_o, req_valid_o}, '0);
      check("R8 reset dst", dst_o, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: 32/32 with negative indices, 64-bit base
      iv = pat(32'h1357);
      iv[31:0] = 32'hFFFF_FFF0; iv[95:64] = 32'h8000_0000;
      run_op("R2 narrow idx sign-ext", 64'h0000_7F00_0000_1000, 32'hFFFF_FF00, 2'd2,
             iv, 1'b0, 1'b0, 2'd2, 8'hFF, pat(32'h42), 1'b0);
      // R1 every scale code
      for (int s = 0; s < 4; s++)
         run_op("R1 scale", 64'h0000_0001_0000_0000 + 64'(s), 32'h0000_0040, 2'(s),
                pat(32'h99 + 32'(s)), 1'b0, 1'b0, 2'd3, 8'h5A, pat(32'h7), 1'b0);
      // R4 R5: wide idx, narrow data: half vector, upper cleared
      run_op("R5 half vector", 64'hFFFF_0000_0000_0000, 32'h10, 2'd3, pat(32'hBEEF),
             1'b1, 1'b0, 2'd2, 8'hFF, {VEC_W{1'b1}}, 1'b0);
      // R4 narrow idx, wide data
      run_op("R4 narrow idx wide data", 64'h2000, 32'hFFFF_FFFC, 2'd3, pat(32'hC0DE),
             1'b0, 1'b1, 2'd2, 8'hFF, pat(32'h3), 1'b0);
      // R8 64/64
      run_op("R8 wide/wide", 64'h0123_4567_89AB_CDE0, 32'h8, 2'd0, pat(32'hFACE),
             1'b1, 1'b1, 2'd2, 8'h0F, pat(32'h11), 1'b0);
      // R6 sparse mask keeps old lanes
      run_op("R6 partial mask", 64'h4000, 32'h0, 2'd2, pat(32'h5),
             1'b0, 1'b0, 2'd2, 8'b1001_0010, pat(32'h77), 1'b0);
      // R3 truncation modes
      run_op("R3 mode16", 64'hABCD_1234_5678_FFF0, 32'h0000_0100, 2'd1, pat(32'h6),
             1'b0, 1'b0, 2'd0, 8'hFF, '0, 1'b0);
      run_op("R3 mode32", 64'hABCD_1234_FFFF_FF00, 32'h0000_0200, 2'd3, pat(32'h8),
             1'b1, 1'b1, 2'd1, 8'hFF, '0, 1'b0);
      // R9 empty mask and R4 mask bits above count ignored
      run_op("R9 empty mask", 64'h5000, 32'h0, 2'd0, pat(32'h9), 1'b0, 1'b0, 2'd2,
             8'h00, pat(32'h12), 1'b0);
      run_op("R4 upper mask ignored", 64'h6000, 32'h0, 2'd0, pat(32'hA), 1'b1, 1'b0,
             2'd2, 8'hF0, pat(32'h13), 1'b0);
      // R7 back-pressure, R10 start while busy
      ready_pat = 8'b1011_0010;
      run_op("R7 backpressure", 64'h7000_0000, 32'hFFFF_FFF8, 2'd2, pat(32'hB),
             1'b0, 1'b0, 2'd2, 8'hFF, pat(32'h14), 1'b0);
      run_op("R10 start while busy", 64'h8000_0000, 32'h4, 2'd3, pat(32'hC),
             1'b0, 1'b1, 2'd2, 8'h0B, pat(32'h15), 1'b1);
      ready_pat = 8'hFF;
      repeat (4) @(negedge clk);
      check("R7 all requests seen", 256'(exp_addr_q.size()), '0);
      check("R9 all completions seen", 256'(exp_dst_q.size()), '0);
      check("R10 no extra operation", {255'd0, busy_o}, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule